// File: doc/BRIEF.md
# Serial Audio Word Receiver

This block takes a two-channel serial audio stream made of a bit clock, a word-rate (frame) clock and one data line. All three come from outside the chip. The block hands left and right 16-bit signed samples to logic running on the system clock, which is 384 times the sample rate. The three serial inputs go through two-stage synchronizers into the system clock domain. The block looks for falling edges of the synchronized bit clock and shifts in one data bit at each falling edge. It closes a word on every frame-clock transition.

The level of the frame clock while a word is being sent selects its channel: high means left and low means right. A sender may give more than 16 bit clocks per word. The block then keeps only the last 16 bits shifted in before the frame edge. A word that ends with fewer than 16 bits is reported as a framing error, and the block keeps the sample it held before. A single-cycle strobe marks a new sample pair each time a complete right-channel word closes.

Top module: `serial_word_rx`

## Requirements
- R1: Each word is 16 bits in two's complement, sent most significant bit first. A data bit is sampled on each falling edge of the bit clock, as seen after the synchronizer.
- R2: A frame-clock transition closes the current word. If the frame clock was high during the word, the word goes to `left_o`. If it was low, the word goes to `right_o`.
- R3: When a word has more than 16 bit-clock falling edges, the sample is the last 16 bits shifted in before the frame-clock transition. Earlier bits are dropped.
- R4: `pair_valid_o` pulses high for exactly one cycle when a complete right-channel word closes. During that cycle `left_o` and `right_o` both hold the current pair.
- R5: When a closing word has fewer than 16 falling edges, the output for that channel keeps its previous value. If the short word is a right-channel word, no `pair_valid_o` pulse is raised.
- R6: `frame_err_o` is updated each time a word closes. It is 1 when that word was short and 0 when it was complete.
- R7: After reset, the first frame-clock transition only opens a word. It raises no error, changes no output and raises no valid pulse.
- R8: During and just after reset, `left_o`, `right_o`, `pair_valid_o` and `frame_err_o` are all zero.
- R9: The outputs update within 6 system clock cycles of a frame-clock transition at the pins. Between word closures they stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (384 times the sample rate) |
| rst_n | input | 1 | Asynchronous active-low reset |
| bck_in | input | 1 | Serial bit clock from outside the chip |
| lrck_in | input | 1 | Frame clock; high = left word, low = right word |
| sdata_in | input | 1 | Serial data, MSB first |
| left_o | output | 16 | Latest complete left sample |
| right_o | output | 16 | Latest complete right sample |
| pair_valid_o | output | 1 | One-cycle strobe: new sample pair ready |
| frame_err_o | output | 1 | Last closed word had fewer than 16 bits |

## Verification
The assertions assume that every bit-clock phase lasts at least two system clock cycles. They also assume that the data line is stable across each falling edge, and that no frame-clock transition arrives in the same synchronized cycle as a bit-clock falling edge. The stimulus meets these conditions by construction. Each bit-clock phase lasts three system clocks. Data changes only while the bit clock is low, and well before the next falling edge. The frame clock moves one half-bit after the last falling edge of a word. Word lengths are swept from 16 up to 32 bits, and short words of 12 and 15 bits are added.

// File: rtl/serial_word_rx.sv
module serial_word_rx #(
  parameter int WORD_W = 16,
  parameter int SYNC_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bck_in,
  input  logic              lrck_in,
  input  logic              sdata_in,
  output logic [WORD_W-1:0] left_o,
  output logic [WORD_W-1:0] right_o,
  output logic              pair_valid_o,
  output logic              frame_err_o
);
  localparam int CNT_W = $clog2(WORD_W + 1);

  logic [SYNC_W-1:0] bck_q, lr_q, dat_q;
  logic              bck_d, lr_d, primed;
  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  bitcnt;

  wire bck_s      = bck_q[SYNC_W-1];
  wire lr_s       = lr_q[SYNC_W-1];
  wire dat_s      = dat_q[SYNC_W-1];
  wire bck_fall   = bck_d & ~bck_s;
  wire lr_edge    = lr_d ^ lr_s;
  wire word_close = lr_edge & primed;
  wire closed_l   = lr_d;
  wire short_word = bitcnt < CNT_W'(WORD_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bck_q <= '0;
      lr_q  <= '0;
      dat_q <= '0;
      bck_d <= 1'b0;
      lr_d  <= 1'b0;
    end else begin
      bck_q <= {bck_q[SYNC_W-2:0], bck_in};
      lr_q  <= {lr_q[SYNC_W-2:0], lrck_in};
      dat_q <= {dat_q[SYNC_W-2:0], sdata_in};
      bck_d <= bck_s;
      lr_d  <= lr_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '0;
      bitcnt <= '0;
      primed <= 1'b0;
    end else begin
      if (bck_fall) shreg <= {shreg[WORD_W-2:0], dat_s};
      if (lr_edge) begin
        primed <= 1'b1;
        bitcnt <= bck_fall ? CNT_W'(1) : '0;
      end else if (bck_fall && short_word) begin
        bitcnt <= bitcnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_o       <= '0;
      right_o      <= '0;
      pair_valid_o <= 1'b0;
      frame_err_o  <= 1'b0;
    end else begin
      pair_valid_o <= word_close & ~short_word & ~closed_l;
      if (word_close) begin
        frame_err_o <= short_word;
        if (!short_word) begin
          if (closed_l) left_o  <= shreg;
          else          right_o <= shreg;
        end
      end
    end
  end
endmodule

// File: rtl/serial_word_rx_chk.sv
module serial_word_rx_chk #(
  parameter int WORD_W = 16,
  parameter int CNT_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              word_close,
  input logic              short_word,
  input logic              closed_l,
  input logic [CNT_W-1:0]  bitcnt,
  input logic [WORD_W-1:0] left_o,
  input logic [WORD_W-1:0] right_o,
  input logic              pair_valid_o,
  input logic              frame_err_o
);
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid_o |=> !pair_valid_o); // R4
  AST_VALID_FROM_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid_o |-> ($past(word_close) && !$past(closed_l) && !frame_err_o)); // R4
  AST_SHORT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (word_close && short_word) |=> ($stable(left_o) && $stable(right_o) && !pair_valid_o && frame_err_o)); // R5
  AST_ERR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (word_close && !short_word) |=> !frame_err_o); // R6
  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
    !word_close |=> ($stable(left_o) && $stable(right_o) && $stable(frame_err_o) && !pair_valid_o)); // R9
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    bitcnt <= CNT_W'(WORD_W)); // R3
endmodule

bind serial_word_rx serial_word_rx_chk #(.WORD_W(WORD_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .word_close(word_close), .short_word(short_word),
  .closed_l(closed_l), .bitcnt(bitcnt), .left_o(left_o), .right_o(right_o),
  .pair_valid_o(pair_valid_o), .frame_err_o(frame_err_o)
);

// File: tb/serial_word_rx_tb_top.sv
module serial_word_rx_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bck = 1'b0, lrck = 1'b0, sdat = 1'b0;
  logic [15:0] left_o, right_o;
  logic pair_valid_o, frame_err_o;
  int checks = 0, failures = 0, vcnt = 0, vlong = 0;
  logic vprev = 1'b0;
  bit done = 0;

  always #10 clk = ~clk;

  serial_word_rx dut_i (
    .clk(clk), .rst_n(rst_n), .bck_in(bck), .lrck_in(lrck), .sdata_in(sdat),
    .left_o(left_o), .right_o(right_o), .pair_valid_o(pair_valid_o), .frame_err_o(frame_err_o)
  );

  always @(posedge clk) begin
    if (pair_valid_o) vcnt++;
    if (pair_valid_o && vprev) vlong++;
    vprev <= pair_valid_o;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_lr(input logic lv);
    lrck = lv;
    repeat (12) @(negedge clk);
  endtask

  task automatic send_bits(input logic [15:0] val, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdat = (i < 16) ? val[i] : ~val[i % 16];
      bck = 1'b1;
      repeat (3) @(negedge clk);
      bck = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic frame_chk(input logic [15:0] l, input logic [15:0] r, input int n);
    int v0;
    v0 = vcnt;
    set_lr(1'b1);
    send_bits(l, n);
    set_lr(1'b0);
    check(frame_err_o == 1'b0, "R6 left close", frame_err_o, 0);
    check(left_o == l, "R1 R3 left word", left_o, l);
    send_bits(r, n);
    set_lr(1'b1);
    check(right_o == r, "R2 R3 right word", right_o, r);
    check(left_o == l, "R4 left held at pair", left_o, l);
    check(vcnt == v0 + 1, "R4 one valid per pair", vcnt - v0, 1);
    check(frame_err_o == 1'b0, "R6 right close", frame_err_o, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int lens[5] = '{16, 17, 20, 24, 32};
    logic [15:0] hl, hr;
    int v0;
    repeat (4) @(negedge clk);
    check(left_o == 0 && right_o == 0, "R8 reset samples", {left_o, right_o}, 0);
    check(pair_valid_o == 0 && frame_err_o == 0, "R8 reset flags", {pair_valid_o, frame_err_o}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(left_o == 0 && right_o == 0 && frame_err_o == 0, "R8 after reset", {left_o, right_o}, 0);

    // R7: first transition only opens a word
    set_lr(1'b1);
    check(frame_err_o == 0 && vcnt == 0, "R7 first edge no error", frame_err_o, 0);
    check(left_o == 0 && right_o == 0, "R7 first edge no output", {left_o, right_o}, 0);
    set_lr(1'b0);
    set_lr(1'b1);

    frame_chk(16'h8001, 16'h7FFE, 16);
    frame_chk(16'h0000, 16'hFFFF, 16);
    for (int li = 0; li < 5; li++) begin
      for (int k = 0; k < 6; k++) begin
        frame_chk(16'((k * 16'h1357) ^ (lens[li] << 8)), 16'(16'hA5C3 - k * 16'h0F1D - lens[li]), lens[li]);
      end
    end

    // R5: short right word holds right, no valid
    hl = left_o; hr = right_o; v0 = vcnt;
    set_lr(1'b1);
    send_bits(16'h1234, 16);
    set_lr(1'b0);
    send_bits(16'hBEEF, 12);
    set_lr(1'b1);
    check(frame_err_o == 1, "R5 R6 short right flagged", frame_err_o, 1);
    check(right_o == hr, "R5 right held", right_o, hr);
    check(vcnt == v0, "R5 no valid on short right", vcnt - v0, 0);
    check(left_o == 16'h1234, "R2 left still taken", left_o, 16'h1234);

    // R5: short left word holds left, right pair still valid
    hl = left_o; v0 = vcnt;
    send_bits(16'h4321, 15);
    set_lr(1'b0);
    check(frame_err_o == 1, "R5 R6 short left flagged", frame_err_o, 1);
    check(left_o == hl, "R5 left held", left_o, hl);
    send_bits(16'h0F0F, 16);
    set_lr(1'b1);
    check(right_o == 16'h0F0F, "R2 right after short left", right_o, 16'h0F0F);
    check(frame_err_o == 0, "R6 error cleared", frame_err_o, 0);
    check(vcnt == v0 + 1, "R4 valid after good right", vcnt - v0, 1);

    // R9: outputs steady while bits arrive without a frame edge
    hl = left_o; hr = right_o;
    send_bits(16'hFFFF, 20);
    check(left_o == hl && right_o == hr, "R9 hold between closes", {left_o, right_o}, {hl, hr});
    frame_chk(16'hC0DE, 16'h5EED, 16);

    check(vlong == 0, "R4 pulse width one cycle", vlong, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule